// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Target

This block is a 256-byte memory that sits on a two-wire serial bus as a target device. It watches the clock and data lines, recognises start and stop conditions, and decodes the 7-bit address byte. It responds only when the address equals a fixed base plus a small strap value, so up to eight copies can share one bus. In a write transfer the first byte after the address sets an internal byte pointer, and each byte after that is stored at the pointer. In a read transfer the target sends bytes starting at the pointer until the controller declines one.

Both lines are sampled on a fast system clock through a synchroniser. The target has no drive-high path. It has a single pull-low enable for the data line and never touches the clock line. On every reset the block copies a full initial image into its array through a load port, one byte per clock. The bus is ignored until that copy is complete.

Top module: `smbus_eeprom_target`

## Requirements
- R1: Each transfer begins with an address byte: a 7-bit address, most significant bit first, followed by a direction bit (1 = read). The target pulls the data line low in the acknowledge slot only when the address equals 0x50 + `addr_sel`. For any other address it never pulls the line and its pointer and memory are left unchanged.
- R2: In a write transfer, the first byte after the address byte is acknowledged and loaded into the pointer. It is not stored.
- R3: Each later byte of the same write transfer is acknowledged and stored at the pointer. The pointer then advances by one modulo 256, so 0xFF wraps to 0x00.
- R4: Each byte of a read transfer is the memory content at the pointer, sent most significant bit first. The pointer then advances by one, wrapping 0xFF to 0x00.
- R5: When the controller does not acknowledge a read byte, the target releases the data line and sends nothing more until the next start. The pointer stays one past the last byte sent.
- R6: On reset, `load_busy` is high for exactly 256 clocks while `img_addr` steps through 0..255. Each byte of `img_data` is written to the matching location. The pointer is 0 and all bus activity is ignored until `load_busy` falls.
- R7: `accessed` is 0 after reset. It becomes 1 when a transfer addresses this target, in either direction, and then stays at 1 until the next reset.
- R8: A repeated start (data falling while the clock is high, with no stop before it) returns the target to address matching. A pointer set by a write can therefore be followed directly by a read.
- R9: A stop (data rising while the clock is high) ends any transfer. The target changes its data-line pull only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the image reload |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_pull | output | 1 | When 1, the target pulls the data line low |
| addr_sel | input | 3 | Static strap added to 0x50 to form the target address |
| img_addr | output | 8 | Byte index requested from the initial image during reload |
| img_data | input | 8 | Initial image byte for `img_addr`, same cycle |
| load_busy | output | 1 | High while the image is being copied in |
| accessed | output | 1 | Sticky flag for a transfer addressed to this target |

## Verification
The assertions assume a well-behaved controller. The data line changes only while the clock is low, except for a start or a stop. No start or stop is issued while the target is pulling the data line low. Each clock phase lasts longer than the synchroniser delay. The stimulus tasks enforce these rules: they change the data line a quarter period after the clock falls, they release it before the acknowledge slots, and they hold each phase for ten system clocks. Random sequences of write bursts, read bursts and pointer-set-then-read transfers are mixed with directed cases. The directed cases cover wrap at 0xFF, foreign addresses, traffic during reload and a second reset.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;

   localparam int BYTE_W  = 8;
   localparam int ADDR7_W = 7;
   localparam int BITS_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_WR_BYTE,
      ST_ACK_WR,
      ST_RD_BYTE,
      ST_RD_ACK,
      ST_IGNORE
   } tgt_state_e;

   // one-cycle requests from the bus engine to the byte store
   typedef struct packed {
      logic set_ptr;
      logic store;
      logic advance;
   } mem_cmd_t;

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s,
   output logic line_rise,
   output logic line_fall
);

   logic [STAGES:0] pipe;
   logic            prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {(STAGES + 1){IDLE_VAL}};
      end else begin
         pipe <= {pipe[STAGES-1:0], line_i};
      end
   end

   assign line_s    = pipe[STAGES-1];
   assign prev      = pipe[STAGES];
   assign line_rise = line_s & ~prev;
   assign line_fall = ~line_s & prev;

endmodule

// File: rtl/smbus_target_fsm.sv
module smbus_target_fsm
   import smbus_eeprom_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               scl_s,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               sda_rise,
   input  logic               sda_fall,
   input  logic [ADDR7_W-1:0] my_addr,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               sda_pull,
   output mem_cmd_t           cmd,
   output logic [BYTE_W-1:0]  wr_byte,
   output logic               addr_hit
);

   localparam logic [BITS_W-1:0] FULL = BITS_W'(BYTE_W);

   tgt_state_e        state;
   logic [BITS_W-1:0] bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic              rnw;
   logic              first;
   logic              ctl_ack;
   logic              start_cond;
   logic              stop_cond;

   // clock high in this and the previous sample
   assign start_cond = sda_fall & scl_s & ~scl_rise;
   assign stop_cond  = sda_rise & scl_s & ~scl_rise;
   assign wr_byte    = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rnw      <= 1'b0;
         first    <= 1'b0;
         ctl_ack  <= 1'b0;
         sda_pull <= 1'b0;
         cmd      <= '0;
         addr_hit <= 1'b0;
      end else begin
         cmd      <= '0;
         addr_hit <= 1'b0;
         if (!enable) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else if (start_cond) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            first    <= 1'b1;
            sda_pull <= 1'b0;
         end else if (stop_cond) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_WR_BYTE: begin
                  if (scl_rise && bit_cnt != FULL) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == FULL) begin
                     if (state == ST_ADDR) begin
                        if (rx_sh[BYTE_W-1:1] == my_addr) begin
                           sda_pull <= 1'b1;
                           rnw      <= rx_sh[0];
                           addr_hit <= 1'b1;
                           state    <= ST_ACK_ADDR;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else begin
                        sda_pull    <= 1'b1;
                        cmd.set_ptr <= first;
                        cmd.store   <= ~first;
                        first       <= 1'b0;
                        state       <= ST_ACK_WR;
                     end
                  end
               end
               ST_ACK_ADDR: begin
                  if (scl_fall) begin
                     if (rnw) begin
                        tx_sh    <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                        bit_cnt  <= BITS_W'(1);
                        state    <= ST_RD_BYTE;
                     end else begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_WR_BYTE;
                     end
                  end
               end
               ST_ACK_WR: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     bit_cnt  <= '0;
                     state    <= ST_WR_BYTE;
                  end
               end
               ST_RD_BYTE: begin
                  if (scl_fall) begin
                     if (bit_cnt == FULL) begin
                        sda_pull    <= 1'b0;
                        cmd.advance <= 1'b1;
                        state       <= ST_RD_ACK;
                     end else begin
                        sda_pull <= ~tx_sh[BYTE_W-2];
                        tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                        bit_cnt  <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     ctl_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (ctl_ack) begin
                        tx_sh    <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                        bit_cnt  <= BITS_W'(1);
                        state    <= ST_RD_BYTE;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               default: begin
                  sda_pull <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store
   import smbus_eeprom_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mem_cmd_t          cmd,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic [BYTE_W-1:0] rd_data,
   output logic [AW-1:0]     ptr,
   output logic [AW-1:0]     img_addr,
   input  logic [BYTE_W-1:0] img_data,
   output logic              load_busy
);

   localparam int DEPTH = 1 << AW;

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]     ld_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_cnt    <= '0;
         load_busy <= 1'b1;
      end else if (load_busy) begin
         ld_cnt <= ld_cnt + 1'b1;
         if (ld_cnt == {AW{1'b1}}) begin
            load_busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (load_busy) begin
         mem[ld_cnt] <= img_data;
      end else if (cmd.store) begin
         mem[ptr] <= wr_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load_busy) begin
         ptr <= '0;
      end else if (cmd.set_ptr) begin
         ptr <= wr_byte[AW-1:0];
      end else if (cmd.store || cmd.advance) begin
         ptr <= ptr + 1'b1;
      end
   end

   assign rd_data  = mem[ptr];
   assign img_addr = ld_cnt;

endmodule

// File: rtl/smbus_eeprom_target.sv
module smbus_eeprom_target
   import smbus_eeprom_pkg::*;
#(
   parameter int               ADDR_W      = 8,
   parameter int               SEL_W       = 3,
   parameter int               SYNC_STAGES = 2,
   parameter logic [ADDR7_W-1:0] BASE_ADDR = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull,
   input  logic [SEL_W-1:0]  addr_sel,
   output logic [ADDR_W-1:0] img_addr,
   input  logic [BYTE_W-1:0] img_data,
   output logic              load_busy,
   output logic              accessed
);

   localparam int NLINES  = 2;
   localparam int TOP_ADR = int'(BASE_ADDR) + (1 << SEL_W) - 1;

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_aw
      $error("ADDR_W must lie in 1..8");
   end
   if (SEL_W < 1 || TOP_ADR > 127) begin : g_bad_sel
      $error("address strap range leaves the 7-bit space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] lvl;
   logic [NLINES-1:0] rise;
   logic [NLINES-1:0] fall;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_sync
      smbus_line_sync #(
         .STAGES   (SYNC_STAGES),
         .IDLE_VAL (1'b1)
      ) u_sync (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_i    (raw[g]),
         .line_s    (lvl[g]),
         .line_rise (rise[g]),
         .line_fall (fall[g])
      );
   end

   logic                scl_s;
   logic [ADDR7_W-1:0]  my_addr;
   logic [BYTE_W-1:0]   rd_data;
   logic [BYTE_W-1:0]   wr_byte;
   logic [ADDR_W-1:0]   ptr;
   logic                addr_hit;
   logic                ptr_load;
   mem_cmd_t            cmd;

   assign scl_s    = lvl[0];
   assign my_addr  = BASE_ADDR + ADDR7_W'(addr_sel);
   assign ptr_load = cmd.set_ptr;

   smbus_target_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (~load_busy),
      .scl_s    (lvl[0]),
      .sda_s    (lvl[1]),
      .scl_rise (rise[0]),
      .scl_fall (fall[0]),
      .sda_rise (rise[1]),
      .sda_fall (fall[1]),
      .my_addr  (my_addr),
      .rd_data  (rd_data),
      .sda_pull (sda_pull),
      .cmd      (cmd),
      .wr_byte  (wr_byte),
      .addr_hit (addr_hit)
   );

   eeprom_byte_store #(
      .AW (ADDR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .wr_byte   (wr_byte),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .img_addr  (img_addr),
      .img_data  (img_data),
      .load_busy (load_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accessed <= 1'b0;
      end else if (addr_hit) begin
         accessed <= 1'b1;
      end
   end

endmodule

// File: rtl/smbus_eeprom_target_chk.sv
module smbus_eeprom_target_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_pull,
   input logic          scl_s,
   input logic          load_busy,
   input logic          accessed,
   input logic [AW-1:0] ptr,
   input logic          ptr_load
);

   AST_QUIET_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
      load_busy |-> !sda_pull) else $error("pull during reload"); // R6

   AST_PTR_ZERO_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
      load_busy |-> ptr == '0) else $error("pointer moved during reload"); // R6

   AST_ACCESSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      accessed |=> accessed) else $error("accessed flag dropped"); // R7

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr) |-> ($past(ptr_load) || ptr == AW'($past(ptr) + 1'b1)))
      else $error("pointer jumped"); // R3

   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s) else $error("pull changed with clock high"); // R9

endmodule

bind smbus_eeprom_target smbus_eeprom_target_chk #(.AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_pull  (sda_pull),
   .scl_s     (scl_s),
   .load_busy (load_busy),
   .accessed  (accessed),
   .ptr       (ptr),
   .ptr_load  (ptr_load)
);

// File: tb/smbus_eeprom_target_test.sv
`timescale 1ns/1ps
module smbus_eeprom_target_test;

   localparam time Q = 25ns;
   localparam logic [7:0] MYW = {7'h55, 1'b0};
   localparam logic [7:0] MYR = {7'h55, 1'b1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [7:0] img_addr;
   logic [7:0] img_data;
   logic       load_busy;
   logic       accessed;
   wire        sda_line = sda_m & ~sda_pull;

   int n_tests = 0;
   int n_fail = 0;
   int pull_bad = 0;
   bit done = 1'b0;
   logic [7:0] mdl [256];
   logic [7:0] mptr;
   logic       pull_q = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] img_fn(input logic [7:0] a);
      return (a * 8'd29) ^ 8'h5A;
   endfunction

   assign img_data = img_fn(img_addr);

   smbus_eeprom_target uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sda_pull  (sda_pull),
      .addr_sel  (3'd5),
      .img_addr  (img_addr),
      .img_data  (img_data),
      .load_busy (load_busy),
      .accessed  (accessed)
   );

   // R9: the pull may only change while the clock line is low
   always @(posedge clk) begin
      if (rst_n && sda_pull !== pull_q && scl === 1'b1) pull_bad++;
      pull_q <= sda_pull;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bit_wr(input logic b);
      #Q sda_m = b;
      #Q scl = 1'b1;
      #(2*Q) scl = 1'b0;
   endtask

   task automatic bit_rd(output logic b);
      #Q sda_m = 1'b1;
      #Q scl = 1'b1;
      #Q b = sda_line;
      #Q scl = 1'b0;
   endtask

   task automatic bus_start();
      #Q sda_m = 1'b1;
      #Q scl = 1'b1;
      #Q sda_m = 1'b0;
      #Q scl = 1'b0;
   endtask

   task automatic bus_stop();
      #Q sda_m = 1'b0;
      #Q scl = 1'b1;
      #Q sda_m = 1'b1;
      #Q;
   endtask

   task automatic send(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bit_wr(b[i]);
      bit_rd(s);
      acked = ~s;
   endtask

   task automatic recv(output logic [7:0] b, input logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_rd(s);
         b[i] = s;
      end
      bit_wr(~ack);
   endtask

   task automatic do_write(input logic [7:0] p, input int n, input bit stop_after);
      logic a;
      logic [7:0] d;
      bus_start();
      send(MYW, a);
      chk("R1 address ack (write)", a, 1'b1);
      send(p, a);
      chk("R2 pointer byte ack", a, 1'b1);
      mptr = p;
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         send(d, a);
         chk("R3 data byte ack", a, 1'b1);
         mdl[mptr] = d;
         mptr = mptr + 1'b1;
      end
      if (stop_after) bus_stop();
   endtask

   task automatic do_read(input int n, input string tag);
      logic a;
      logic [7:0] b;
      bus_start();
      send(MYR, a);
      chk({tag, " address ack (read)"}, a, 1'b1);
      for (int i = 0; i < n; i++) begin
         recv(b, i < n - 1);
         chk({tag, " R4 read data"}, b, mdl[mptr]);
         mptr = mptr + 1'b1;
      end
      #Q chk("R5 data line released after NACK", sda_pull, 1'b0);
      bus_stop();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) mdl[i] = img_fn(8'(i));
      mptr = 8'h00;
   endtask

   initial begin
      logic a;
      int   cyc;
      void'($urandom(32'd7741));
      repeat (2) @(negedge clk);
      chk("R6 reset: load_busy", load_busy, 1'b1);
      chk("R6 reset: no pull", sda_pull, 1'b0);
      chk("R7 reset: accessed clear", accessed, 1'b0);
      do_reset();
      cyc = 0;
      while (load_busy) begin
         @(negedge clk);
         cyc++;
      end
      chk("R6 reload length in cycles", cyc, 256);

      // R6: addressed while reloading -> ignored
      do_reset();
      bus_start();
      send(MYW, a);
      chk("R6 no ack during reload", a, 1'b0);
      bus_stop();
      while (load_busy) @(negedge clk);
      chk("R7 not set by ignored transfer", accessed, 1'b0);

      // R1: foreign addresses
      bus_start();
      send({7'h54, 1'b0}, a);
      chk("R1 no ack for 0x54", a, 1'b0);
      send(8'h33, a);
      chk("R1 ignored data not acked", a, 1'b0);
      bus_stop();
      bus_start();
      send({7'h56, 1'b1}, a);
      chk("R1 no ack for 0x56", a, 1'b0);
      bus_stop();
      chk("R7 foreign address leaves accessed", accessed, 1'b0);
      do_read(3, "R1 pointer untouched; R6 image");
      chk("R7 accessed after read", accessed, 1'b1);

      // R3/R8: write across the top of the array, read back with repeated start
      do_write(8'hFE, 4, 1'b1);
      do_write(8'hFE, 0, 1'b0);
      do_read(4, "R8 R3 wrap");
      do_write(8'hFF, 0, 1'b0);
      do_read(2, "R4 wrap");

      // R2: pointer-only write, then a plain read
      do_write(8'h40, 0, 1'b1);
      do_read(1, "R2");

      // R5: NACK ends burst; next read continues one past last byte
      do_write(8'h10, 0, 1'b0);
      do_read(2, "R5");
      do_read(1, "R5 continue");

      // random mix
      for (int t = 0; t < 40; t++) begin
         int op;
         op = int'($urandom % 3);
         if (op == 0) do_write(8'($urandom), int'($urandom % 5), 1'b1);
         else if (op == 1) do_read(1 + int'($urandom % 4), "R4 random");
         else begin
            do_write(8'($urandom), 0, 1'b0);
            do_read(1 + int'($urandom % 3), "R8 random");
         end
      end

      // R6/R7: second reset restores the image and clears state
      do_reset();
      while (load_busy) @(negedge clk);
      chk("R7 cleared by second reset", accessed, 1'b0);
      do_read(4, "R6 image after second reset");

      chk("R9 pull changed only with clock low", pull_bad, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule